// File: doc/BRIEF.md
# Segmented Linear Address Generator

This block turns a 32-bit offset into a 32-bit linear address by adding the base of one of six segment registers. The six bases (code, data, stack and three extra data segments) are loaded one at a time through a write port and hold their value until written again. Each request carries an access kind, the index of the general register used as the operand base (if any), an optional segment override and the offset.

The segment is chosen by a fixed rule. Instruction fetches always use the code segment. Stack accesses always use the stack segment. Data accesses use a valid override if one is given. Without an override, they use the stack segment when the operand base register is the frame pointer (register index 5), and the data segment in all other cases. The sum is registered, so the address and the chosen segment code appear one cycle after the request. A loader can change a base while traffic runs: a request in the same cycle as the write still sees the old base, and later requests see the new one.

Top module: `seg_addr_gen`

## Requirements
- R1: After reset, out_valid and out_addr are 0 and every segment base is 0, so each segment maps an offset to itself.
- R2: With wr_en high, wr_base is stored into the segment named by wr_sel (0 code, 1 data, 2 stack, 3/4/5 extra data). Codes 6 and 7 change no base.
- R3: A request with req_valid high gives out_valid high one cycle later, with out_addr = (base of chosen segment + req_offset) mod 2^32 and out_seg = the chosen segment code.
- R4: req_kind 0 (fetch) always uses the code segment (0), whatever the override.
- R5: req_kind 1 (stack) always uses the stack segment (2), whatever the override.
- R6: For req_kind 2 or 3 (data) with no valid override, req_base_used high and req_basereg equal to 5, the stack segment (2) is used.
- R7: For data requests with no valid override and no frame-pointer base, the data segment (1) is used.
- R8: For data requests with ovr_valid high and ovr_sel from 0 to 5, that segment is used. An ovr_sel of 6 or 7 is ignored and the default rule applies.
- R9: A base write and a request in the same cycle: the request uses the old base, and the next request uses the new base.
- R10: A cycle without a request gives out_valid low, and out_addr and out_seg keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Base write strobe |
| wr_sel | input | 3 | Segment code to write |
| wr_base | input | 32 | New base value |
| req_valid | input | 1 | Address request strobe |
| req_kind | input | 2 | 0 fetch, 1 stack, 2/3 data |
| req_base_used | input | 1 | Operand uses a base register |
| req_basereg | input | 3 | Index of the base register |
| ovr_valid | input | 1 | Segment override present |
| ovr_sel | input | 3 | Override segment code |
| req_offset | input | 32 | Offset within the segment |
| out_valid | output | 1 | Address valid, one cycle after the request |
| out_addr | output | 32 | Linear address |
| out_seg | output | 3 | Segment code used |

## Verification
Every result is due exactly one clock edge after the request. Stimulus is driven on the falling edge, and outputs are sampled 1 ns after the next rising edge, before the following falling edge changes any input. Base writes take effect at the same rising edge. The same-cycle test therefore samples the request issued with the write for the old base, and the following request for the new one. Idle cycles are sampled on the same one-edge schedule to confirm that the output registers hold.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

  localparam int SEG_CODE_IDX  = 0;
  localparam int SEG_DATA_IDX  = 1;
  localparam int SEG_STACK_IDX = 2;

  typedef enum logic [1:0] {
    ACC_FETCH    = 2'd0,
    ACC_STACK    = 2'd1,
    ACC_DATA     = 2'd2,
    ACC_DATA_ALT = 2'd3
  } acc_kind_e;

  // True when a segment code names an existing segment register.
  function automatic logic seg_code_ok(input logic [2:0] code, input int unsigned nseg);
    return (32'(code) < nseg);
  endfunction

endpackage

// File: rtl/seg_base_file.sv
module seg_base_file #(
  parameter int ADDR_W  = 32,
  parameter int NUM_SEG = 6,
  parameter int SEL_W   = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [SEL_W-1:0]                wr_sel,
  input  logic [ADDR_W-1:0]               wr_base,
  output logic [NUM_SEG-1:0]              wr_hit,
  output logic [NUM_SEG-1:0][ADDR_W-1:0]  bases
);

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    assign wr_hit[s] = wr_en && (32'(wr_sel) == s);

    always_ff @(posedge clk) begin
      if (!rst_n)         bases[s] <= '0;
      else if (wr_hit[s]) bases[s] <= wr_base;
    end
  end

endmodule

// File: rtl/seg_select.sv
module seg_select
  import seg_addr_pkg::*;
#(
  parameter int NUM_SEG = 6,
  parameter int SEL_W   = 3,
  parameter int REG_W   = 3,
  parameter int FP_IDX  = 5
) (
  input  logic [1:0]       req_kind,
  input  logic             req_base_used,
  input  logic [REG_W-1:0] req_basereg,
  input  logic             ovr_valid,
  input  logic [SEL_W-1:0] ovr_sel,
  output logic             ovr_taken,
  output logic             fp_default,
  output logic [SEL_W-1:0] seg_sel
);

  acc_kind_e kind;
  logic      is_data;

  assign kind       = acc_kind_e'(req_kind);
  assign is_data    = (kind == ACC_DATA) || (kind == ACC_DATA_ALT);
  assign ovr_taken  = is_data && ovr_valid && (32'(ovr_sel) < NUM_SEG);
  assign fp_default = is_data && !ovr_taken && req_base_used &&
                      (32'(req_basereg) == FP_IDX);

  always_comb begin
    unique case (kind)
      ACC_FETCH: seg_sel = SEL_W'(SEG_CODE_IDX);
      ACC_STACK: seg_sel = SEL_W'(SEG_STACK_IDX);
      default: begin
        if (ovr_taken)       seg_sel = ovr_sel;
        else if (fp_default) seg_sel = SEL_W'(SEG_STACK_IDX);
        else                 seg_sel = SEL_W'(SEG_DATA_IDX);
      end
    endcase
  end

endmodule

// File: rtl/seg_addr_stage.sv
module seg_addr_stage #(
  parameter int ADDR_W  = 32,
  parameter int NUM_SEG = 6,
  parameter int SEL_W   = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            req_valid,
  input  logic [SEL_W-1:0]                seg_sel,
  input  logic [NUM_SEG-1:0][ADDR_W-1:0]  bases,
  input  logic [ADDR_W-1:0]               req_offset,
  output logic                            out_valid,
  output logic [ADDR_W-1:0]               out_addr,
  output logic [SEL_W-1:0]                out_seg
);

  // Wrapping add: carry out of the top bit is dropped.
  function automatic logic [ADDR_W-1:0] wrap_add(input logic [ADDR_W-1:0] a,
                                                 input logic [ADDR_W-1:0] b);
    return a + b;
  endfunction

  logic [ADDR_W-1:0] base_pick;
  logic [ADDR_W-1:0] sum_next;

  always_comb begin
    base_pick = '0;
    for (int s = 0; s < NUM_SEG; s++) begin
      if (32'(seg_sel) == s) base_pick = bases[s];
    end
  end

  assign sum_next = wrap_add(base_pick, req_offset);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_seg   <= '0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        out_addr <= sum_next;
        out_seg  <= seg_sel;
      end
    end
  end

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
  parameter int ADDR_W  = 32,
  parameter int NUM_SEG = 6,
  parameter int SEL_W   = 3,
  parameter int REG_W   = 3,
  parameter int FP_IDX  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [ADDR_W-1:0] wr_base,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic              req_base_used,
  input  logic [REG_W-1:0]  req_basereg,
  input  logic              ovr_valid,
  input  logic [SEL_W-1:0]  ovr_sel,
  input  logic [ADDR_W-1:0] req_offset,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic [SEL_W-1:0]  out_seg
);

  logic [NUM_SEG-1:0]             wr_hit;
  logic [NUM_SEG-1:0][ADDR_W-1:0] bases;
  logic [SEL_W-1:0]               seg_sel;
  logic                           ovr_taken;
  logic                           fp_default;

  seg_base_file #(.ADDR_W(ADDR_W), .NUM_SEG(NUM_SEG), .SEL_W(SEL_W)) base_file_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_base(wr_base), .wr_hit(wr_hit), .bases(bases)
  );

  seg_select #(.NUM_SEG(NUM_SEG), .SEL_W(SEL_W), .REG_W(REG_W), .FP_IDX(FP_IDX)) select_i (
    .req_kind(req_kind), .req_base_used(req_base_used), .req_basereg(req_basereg),
    .ovr_valid(ovr_valid), .ovr_sel(ovr_sel), .ovr_taken(ovr_taken),
    .fp_default(fp_default), .seg_sel(seg_sel)
  );

  seg_addr_stage #(.ADDR_W(ADDR_W), .NUM_SEG(NUM_SEG), .SEL_W(SEL_W)) stage_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .seg_sel(seg_sel),
    .bases(bases), .req_offset(req_offset), .out_valid(out_valid),
    .out_addr(out_addr), .out_seg(out_seg)
  );

endmodule

// File: rtl/seg_addr_chk.sv
module seg_addr_chk #(
  parameter int ADDR_W  = 32,
  parameter int NUM_SEG = 6,
  parameter int SEL_W   = 3,
  parameter int REG_W   = 3,
  parameter int FP_IDX  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [1:0]        req_kind,
  input logic              req_base_used,
  input logic [REG_W-1:0]  req_basereg,
  input logic              ovr_valid,
  input logic [SEL_W-1:0]  ovr_sel,
  input logic [NUM_SEG-1:0] wr_hit,
  input logic              out_valid,
  input logic [ADDR_W-1:0] out_addr,
  input logic [SEL_W-1:0]  out_seg
);

  logic data_req;
  logic good_ovr;
  assign data_req = req_valid && req_kind[1];
  assign good_ovr = ovr_valid && (32'(ovr_sel) < NUM_SEG);

  // R2
  wr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_hit));

  // R3
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(req_valid));

  // R4
  fetch_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'd0) |=> (out_seg == SEL_W'(0)));

  // R5
  stack_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'd1) |=> (out_seg == SEL_W'(2)));

  // R6
  fp_stack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_req && !good_ovr && req_base_used && 32'(req_basereg) == FP_IDX)
      |=> (out_seg == SEL_W'(2)));

  // R7
  data_dflt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_req && !good_ovr && !(req_base_used && 32'(req_basereg) == FP_IDX))
      |=> (out_seg == SEL_W'(1)));

  // R8
  ovr_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_req && good_ovr) |=> (out_seg == $past(ovr_sel)));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(out_addr) && $stable(out_seg)));

endmodule

bind seg_addr_gen seg_addr_chk #(
  .ADDR_W(ADDR_W), .NUM_SEG(NUM_SEG), .SEL_W(SEL_W), .REG_W(REG_W), .FP_IDX(FP_IDX)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
  .req_base_used(req_base_used), .req_basereg(req_basereg),
  .ovr_valid(ovr_valid), .ovr_sel(ovr_sel), .wr_hit(wr_hit),
  .out_valid(out_valid), .out_addr(out_addr), .out_seg(out_seg)
);

// File: tb/seg_addr_gen_tb_top.sv
`timescale 1ns/1ps
module seg_addr_gen_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_sel;
  logic [31:0] wr_base;
  logic        req_valid;
  logic [1:0]  req_kind;
  logic        req_base_used;
  logic [2:0]  req_basereg;
  logic        ovr_valid;
  logic [2:0]  ovr_sel;
  logic [31:0] req_offset;
  logic        out_valid;
  logic [31:0] out_addr;
  logic [2:0]  out_seg;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [31:0] model [6];

  always #5 clk = ~clk;

  seg_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_base(wr_base),
    .req_valid(req_valid), .req_kind(req_kind), .req_base_used(req_base_used),
    .req_basereg(req_basereg), .ovr_valid(ovr_valid), .ovr_sel(ovr_sel),
    .req_offset(req_offset), .out_valid(out_valid), .out_addr(out_addr),
    .out_seg(out_seg)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_seg(input logic [1:0] k, input logic bu,
                                         input logic [2:0] br, input logic ov,
                                         input logic [2:0] os);
    if (k == 2'd0) return 3'd0;
    if (k == 2'd1) return 3'd2;
    if (ov && os <= 3'd5) return os;
    if (bu && br == 3'd5) return 3'd2;
    return 3'd1;
  endfunction

  // Called on a falling edge; returns on the next falling edge.
  task automatic request(input logic [1:0] k, input logic bu, input logic [2:0] br,
                         input logic ov, input logic [2:0] os, input logic [31:0] off,
                         input string tag);
    logic [2:0]  s;
    logic [31:0] ea;
    s  = exp_seg(k, bu, br, ov, os);
    ea = model[s] + off;
    req_valid = 1'b1; req_kind = k; req_base_used = bu; req_basereg = br;
    ovr_valid = ov; ovr_sel = os; req_offset = off;
    @(posedge clk); #1;
    check(out_valid === 1'b1, tag, 32'(out_valid), 32'd1);
    check(out_seg === s, tag, 32'(out_seg), 32'(s));
    check(out_addr === ea, tag, out_addr, ea);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic write_base(input logic [2:0] s, input logic [31:0] v);
    wr_en = 1'b1; wr_sel = s; wr_base = v;
    @(negedge clk);
    wr_en = 1'b0;
    if (s <= 3'd5) model[s] = v;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] last_addr;
    logic [2:0]  last_seg;
    int          idx;
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_base = '0;
    req_valid = 1'b0; req_kind = '0; req_base_used = 1'b0; req_basereg = '0;
    ovr_valid = 1'b0; ovr_sel = '0; req_offset = '0;
    for (int s = 0; s < 6; s++) model[s] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(out_valid === 1'b0, "R1 valid", 32'(out_valid), 0);
    check(out_addr === 32'd0, "R1 addr", out_addr, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: zero bases map offset to itself
    for (int s = 0; s < 6; s++)
      request(2'd2, 1'b0, 3'd0, 1'b1, 3'(s), 32'hA5A5_0000 + 32'(s), "R1 zero base");

    // R2: load every base
    for (int s = 0; s < 6; s++)
      write_base(3'(s), 32'h1000_0000 * 32'(s + 1) + 32'(s * 17));
    // R2: codes 6 and 7 change nothing (model untouched)
    write_base(3'd6, 32'hDEAD_BEEF);
    write_base(3'd7, 32'hBEEF_DEAD);
    for (int s = 0; s < 6; s++)
      request(2'd2, 1'b0, 3'd0, 1'b1, 3'(s), 32'h0000_0100, "R2 base readback");

    // R3..R8: sweep of kind, base use, base register, override
    idx = 0;
    for (int k = 0; k < 4; k++)
      for (int bu = 0; bu < 2; bu++)
        for (int br = 0; br < 8; br++)
          for (int ov = 0; ov < 2; ov++)
            for (int os = 0; os < 8; os++) begin
              request(2'(k), 1'(bu), 3'(br), 1'(ov), 3'(os),
                      32'hF000_0000 + 32'(idx) * 32'h0123_4567,
                      k == 0 ? "R4 fetch" : k == 1 ? "R5 stack" :
                      (ov == 1 && os < 6) ? "R8 override" :
                      (bu == 1 && br == 5) ? "R6 frame ptr" : "R7 data/R3 sum");
              idx++;
            end

    // R3: wraparound at the top of the address space
    write_base(3'd1, 32'hFFFF_FFF0);
    request(2'd2, 1'b0, 3'd0, 1'b0, 3'd0, 32'h0000_0020, "R3 wrap");
    check(out_addr === 32'h0000_0010, "R3 wrap value", out_addr, 32'h10);

    // R9: same-cycle write sees the old base, next request the new one
    wr_en = 1'b1; wr_sel = 3'd1; wr_base = 32'h7700_0000;
    request(2'd2, 1'b0, 3'd0, 1'b0, 3'd0, 32'h0000_0044, "R9 old base");
    wr_en = 1'b0; model[1] = 32'h7700_0000;
    request(2'd2, 1'b0, 3'd0, 1'b0, 3'd0, 32'h0000_0044, "R9 new base");
    check(out_addr === 32'h7700_0044, "R9 new value", out_addr, 32'h7700_0044);

    // R10: idle cycles hold the output
    last_addr = out_addr; last_seg = out_seg;
    for (int i = 0; i < 4; i++) begin
      req_kind = 2'(i); req_offset = 32'h1234_0000 * 32'(i + 1); ovr_valid = 1'b1;
      ovr_sel = 3'(i);
      @(posedge clk); #1;
      check(out_valid === 1'b0, "R10 valid low", 32'(out_valid), 0);
      check(out_addr === last_addr, "R10 addr hold", out_addr, last_addr);
      check(out_seg === last_seg, "R10 seg hold", 32'(out_seg), 32'(last_seg));
      @(negedge clk);
    end
    finish_run();
  end

endmodule